// File: doc/BRIEF.md
# USB Endpoint State and Selection Manager

This block keeps the control state of every endpoint in a small USB device controller: an enable bit, a data toggle bit, a bank pointer and a received-setup flag. It sits between a CPU register port, a DMA-style data-flow port and the packet engine. It applies three kinds of reset. An endpoint reset wipes the endpoint's working state but keeps its configuration and toggle. A toggle-clear command resets only the toggle. A bus reset disables every endpoint but endpoint 0 and fully resets endpoint 0.

Two endpoint-number registers share one register address. A select pin picks the register that is read and written. One register names the endpoint the CPU works on, and the other names the endpoint the data-flow port works on. The CPU can therefore service endpoint 0 after a SETUP packet without reprogramming the endpoint the data-flow port is using. When bus reset signalling ends, the block raises an end-of-reset flag and latches the negotiated speed.

Top module: `ep_state_mgr`

## Requirements
- R1: After reset, only endpoint 0 is enabled. All toggles, pointers, setup flags, endpoint-reset bits, both endpoint numbers, the data-flow-ready bit, the end-of-reset flag and the speed bit (0 = full speed) are 0. A write of the enable mask takes effect on the next cycle.
- R2: An endpoint reset clears the endpoint's bank pointer and setup flag on the cycle after its bit is written. The endpoint's toggle and enable are kept, and other endpoints are not touched.
- R3: The endpoint-reset readback shows a written bit for exactly one cycle and then reads 0. A bit written for a disabled endpoint is never set and has no effect on that endpoint.
- R4: A successful transfer (`xfer_ok`) flips the toggle of `xfer_ep` if that endpoint is enabled. The toggle-clear command clears the toggle of the CPU-selected endpoint and wins over a flip in the same cycle.
- R5: While `bus_rst` is high, endpoints 1 to 6 are disabled, endpoint 0 keeps its enable, and endpoint 0's pointer, setup flag and toggle are cleared. The toggles of the other endpoints are kept.
- R6: In a cycle with `bus_rst` high, the block ignores endpoint-reset writes, toggle-clear commands, setup events, transfer flips and bank accesses, and cancels any pending endpoint-reset bits.
- R7: `eorst_int` is set on the first cycle after `bus_rst` falls, and `speed_hs` latches `hs_det` at the same time. Writing 1 to `eorst_clr` clears the flag, and a new set in the same cycle wins over the clear.
- R8: `epnum_sel`=0 addresses the CPU endpoint number and `epnum_sel`=1 addresses the data-flow endpoint number, both for writes and for `epnum_rdata`. Writing one register leaves the other unchanged. A written value of 7 or more is ignored.
- R9: A CPU access advances the CPU endpoint's pointer. A data-flow access advances the data-flow endpoint's pointer only while `dfc_grant` is high, and `dfc_grant` is high only when the ready bit is set and that endpoint is enabled. If both ports access the same endpoint in one cycle, the pointer advances once. A disabled endpoint's pointer does not advance.
- R10: `setup_rx` sets the setup flag of `setup_ep` if that endpoint is enabled, and the flag shows on `ep_int`. `setup_clr` clears the flag of the CPU endpoint, and a set in the same cycle wins over the clear.
- R11: A bank pointer wraps modulo 2^PTR_W, so with the default of 64 positions it wraps to 0 after 64 advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_we | input | 1 | Enable-mask write strobe |
| en_wdata | input | 7 | Enable mask, one bit per endpoint |
| en_vec | output | 7 | Current enable bits |
| eprst_we | input | 1 | Endpoint-reset write strobe |
| eprst_wdata | input | 7 | Endpoint-reset bits |
| eprst_rdata | output | 7 | Pending endpoint-reset bits |
| rstdt_cmd | input | 1 | Clear the toggle of the CPU endpoint |
| epnum_sel | input | 1 | 0 = CPU number, 1 = data-flow number |
| epnum_we | input | 1 | Endpoint-number write strobe |
| epnum_wdata | input | 3 | Endpoint-number write value |
| epnum_rdata | output | 3 | Selected endpoint number |
| dfc_rdy_we | input | 1 | Data-flow-ready write strobe |
| dfc_rdy_wdata | input | 1 | Data-flow-ready value |
| dfc_grant | output | 1 | Data-flow port may access its endpoint |
| cpu_acc | input | 1 | CPU bank access |
| dfc_acc | input | 1 | Data-flow bank access |
| cpu_ptr | output | 6 | Pointer of the CPU endpoint |
| dfc_ptr | output | 6 | Pointer of the data-flow endpoint |
| xfer_ok | input | 1 | Transfer completed, flip toggle |
| xfer_ep | input | 3 | Endpoint of the transfer |
| tog_vec | output | 7 | Data toggle bits |
| setup_rx | input | 1 | SETUP packet received |
| setup_ep | input | 3 | Endpoint of the SETUP packet |
| setup_clr | input | 1 | Write-1 clear of the CPU endpoint's setup flag |
| ep_int | output | 7 | Per-endpoint setup interrupt flags |
| bus_rst | input | 1 | Bus reset signalling in progress |
| hs_det | input | 1 | High speed negotiated |
| eorst_clr | input | 1 | Write-1 clear of end-of-reset flag |
| eorst_int | output | 1 | End-of-reset interrupt flag |
| speed_hs | output | 1 | 1 = high speed, 0 = full speed |

## Verification
The reset paths are driven against endpoints that already carry non-zero pointers, set toggles and pending setup flags, so that a reset that clears too much and a reset that clears too little both show up. Each reset kind is also applied in the same cycle as competing commands (toggle flips, setup events, accesses from both ports, endpoint-reset writes). This separates the priority orders of the reset kinds. The two endpoint-number registers are written alternately and read back, which exposes a shared register or a wrong mux. A disabled endpoint and a data-flow port that is not ready are each given stimulus, and the bench checks that nothing moves.

// File: rtl/ep_mgr_pkg.sv
package ep_mgr_pkg;

  // Per-endpoint command bundle decoded by the top level each cycle.
  typedef struct packed {
    logic ep_clr;    // endpoint reset takes effect
    logic tog_clr;   // clear data toggle
    logic tog_flip;  // transfer done: flip toggle
    logic ptr_inc;   // bank access: advance pointer
    logic stp_set;   // setup packet arrived
    logic stp_clr;   // write-1 clear of setup flag
  } slot_cmd_t;

endpackage

// File: rtl/ep_slot.sv
module ep_slot
  import ep_mgr_pkg::*;
#(
  parameter int PTR_W  = 6,
  parameter bit IS_EP0 = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  slot_cmd_t        cmd,
  input  logic             bus_rst,
  input  logic             en_we,
  input  logic             en_wdata,
  output logic             en_o,
  output logic             tog_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             stp_o
);

  logic             en_q, tog_q, stp_q;
  logic             en_d, tog_d, stp_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             wipe, upd;

  // Bus reset wipes endpoint 0 only; otherwise an endpoint reset wipes.
  assign wipe = bus_rst ? IS_EP0 : cmd.ep_clr;
  assign upd  = bus_rst | en_we | (|cmd);

  always_comb begin
    en_d  = en_q;
    tog_d = tog_q;
    ptr_d = ptr_q;
    stp_d = stp_q;
    if (bus_rst) begin
      en_d = IS_EP0 ? en_q : 1'b0;
      if (IS_EP0) tog_d = 1'b0;
    end else begin
      if (en_we) en_d = en_wdata;
      if (cmd.tog_clr)              tog_d = 1'b0;
      else if (cmd.tog_flip && en_q) tog_d = ~tog_q;
    end
    if (wipe) begin
      ptr_d = '0;
      stp_d = 1'b0;
    end else if (!bus_rst) begin
      if (cmd.ptr_inc && en_q) ptr_d = ptr_q + 1'b1;
      if (cmd.stp_set && en_q) stp_d = 1'b1;
      else if (cmd.stp_clr)    stp_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= IS_EP0;
      tog_q <= 1'b0;
      ptr_q <= '0;
      stp_q <= 1'b0;
    end else if (upd) begin
      en_q  <= en_d;
      tog_q <= tog_d;
      ptr_q <= ptr_d;
      stp_q <= stp_d;
    end
  end

  assign en_o  = en_q;
  assign tog_o = tog_q;
  assign ptr_o = ptr_q;
  assign stp_o = stp_q;

endmodule

// File: rtl/ep_sel.sv
module ep_sel #(
  parameter int NUM_EP = 7,
  parameter int EPN_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             we,
  input  logic [EPN_W-1:0] wdata,
  input  logic             rdy_we,
  input  logic             rdy_wdata,
  output logic [EPN_W-1:0] cpu_ep,
  output logic [EPN_W-1:0] dfc_ep,
  output logic [EPN_W-1:0] rdata,
  output logic             dfc_rdy
);

  logic [EPN_W-1:0] cpu_q, dfc_q;
  logic             rdy_q;
  logic             wr_ok, cpu_en, dfc_en;

  assign wr_ok  = we && (int'(wdata) < NUM_EP);
  assign cpu_en = wr_ok && !sel;
  assign dfc_en = wr_ok && sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_q <= '0;
      dfc_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      if (cpu_en) cpu_q <= wdata;
      if (dfc_en) dfc_q <= wdata;
      if (rdy_we) rdy_q <= rdy_wdata;
    end
  end

  assign cpu_ep  = cpu_q;
  assign dfc_ep  = dfc_q;
  assign rdata   = sel ? dfc_q : cpu_q;
  assign dfc_rdy = rdy_q;

endmodule

// File: rtl/ep_state_mgr.sv
module ep_state_mgr
  import ep_mgr_pkg::*;
#(
  parameter int NUM_EP = 7,
  parameter int PTR_W  = 6,
  localparam int EPN_W = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_we,
  input  logic [NUM_EP-1:0] en_wdata,
  output logic [NUM_EP-1:0] en_vec,
  input  logic              eprst_we,
  input  logic [NUM_EP-1:0] eprst_wdata,
  output logic [NUM_EP-1:0] eprst_rdata,
  input  logic              rstdt_cmd,
  input  logic              epnum_sel,
  input  logic              epnum_we,
  input  logic [EPN_W-1:0]  epnum_wdata,
  output logic [EPN_W-1:0]  epnum_rdata,
  input  logic              dfc_rdy_we,
  input  logic              dfc_rdy_wdata,
  output logic              dfc_grant,
  input  logic              cpu_acc,
  input  logic              dfc_acc,
  output logic [PTR_W-1:0]  cpu_ptr,
  output logic [PTR_W-1:0]  dfc_ptr,
  input  logic              xfer_ok,
  input  logic [EPN_W-1:0]  xfer_ep,
  output logic [NUM_EP-1:0] tog_vec,
  input  logic              setup_rx,
  input  logic [EPN_W-1:0]  setup_ep,
  input  logic              setup_clr,
  output logic [NUM_EP-1:0] ep_int,
  input  logic              bus_rst,
  input  logic              hs_det,
  input  logic              eorst_clr,
  output logic              eorst_int,
  output logic              speed_hs
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  logic [EPN_W-1:0] cpu_ep, dfc_ep;
  logic             dfc_rdy;

  ep_sel #(.NUM_EP(NUM_EP), .EPN_W(EPN_W)) u_sel (
    .clk      (clk),
    .rst_n    (srst_n),
    .sel      (epnum_sel),
    .we       (epnum_we),
    .wdata    (epnum_wdata),
    .rdy_we   (dfc_rdy_we),
    .rdy_wdata(dfc_rdy_wdata),
    .cpu_ep   (cpu_ep),
    .dfc_ep   (dfc_ep),
    .rdata    (epnum_rdata),
    .dfc_rdy  (dfc_rdy)
  );

  logic             live;
  logic [PTR_W-1:0] ptr_arr [NUM_EP];
  slot_cmd_t        cmd     [NUM_EP];
  logic [NUM_EP-1:0] eprst_q, eprst_d;
  logic              eprst_upd;

  assign live      = ~bus_rst;
  assign dfc_grant = dfc_rdy & en_vec[dfc_ep];

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    assign cmd[i].ep_clr   = live & eprst_q[i];
    assign cmd[i].tog_clr  = live & rstdt_cmd & (cpu_ep == EPN_W'(i));
    assign cmd[i].tog_flip = live & xfer_ok & (xfer_ep == EPN_W'(i));
    assign cmd[i].ptr_inc  = live & ((cpu_acc & (cpu_ep == EPN_W'(i))) |
                                     (dfc_acc & dfc_grant & (dfc_ep == EPN_W'(i))));
    assign cmd[i].stp_set  = live & setup_rx & (setup_ep == EPN_W'(i));
    assign cmd[i].stp_clr  = live & setup_clr & (cpu_ep == EPN_W'(i));

    ep_slot #(.PTR_W(PTR_W), .IS_EP0(i == 0)) u_slot (
      .clk     (clk),
      .rst_n   (srst_n),
      .cmd     (cmd[i]),
      .bus_rst (bus_rst),
      .en_we   (en_we),
      .en_wdata(en_wdata[i]),
      .en_o    (en_vec[i]),
      .tog_o   (tog_vec[i]),
      .ptr_o   (ptr_arr[i]),
      .stp_o   (ep_int[i])
    );
  end

  assign cpu_ptr = ptr_arr[cpu_ep];
  assign dfc_ptr = ptr_arr[dfc_ep];

  // Endpoint-reset register: bits for enabled endpoints live one cycle.
  assign eprst_upd = eprst_we | (|eprst_q) | bus_rst;
  always_comb begin
    eprst_d = '0;
    if (!bus_rst && eprst_we) eprst_d = eprst_wdata & en_vec;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)        eprst_q <= '0;
    else if (eprst_upd) eprst_q <= eprst_d;
  end
  assign eprst_rdata = eprst_q;

  // End of bus reset: flag and speed latch.
  logic bus_rst_q, eorst_q, eorst_d, speed_q, speed_d, rst_done;
  assign rst_done = bus_rst_q & ~bus_rst;

  always_comb begin
    eorst_d = eorst_q;
    speed_d = speed_q;
    if (rst_done) begin
      eorst_d = 1'b1;
      speed_d = hs_det;
    end else if (eorst_clr) begin
      eorst_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      bus_rst_q <= 1'b0;
      eorst_q   <= 1'b0;
      speed_q   <= 1'b0;
    end else begin
      bus_rst_q <= bus_rst;
      eorst_q   <= eorst_d;
      speed_q   <= speed_d;
    end
  end

  assign eorst_int = eorst_q;
  assign speed_hs  = speed_q;

endmodule

// File: rtl/ep_state_chk.sv
module ep_state_chk #(
  parameter int NUM_EP = 7,
  parameter int EPN_W  = 3
) (
  input logic              clk,
  input logic              srst_n,
  input logic              bus_rst,
  input logic              bus_rst_q,
  input logic              rstdt_cmd,
  input logic              xfer_ok,
  input logic              eprst_we,
  input logic [NUM_EP-1:0] eprst_q,
  input logic [NUM_EP-1:0] en_vec,
  input logic [NUM_EP-1:0] tog_vec,
  input logic [EPN_W-1:0]  cpu_ep,
  input logic [EPN_W-1:0]  dfc_ep,
  input logic              eorst_int,
  input logic              speed_hs
);

  p_bus_disable_r5: assert property (@(posedge clk) disable iff (!srst_n)
    bus_rst |=> (en_vec[NUM_EP-1:1] == '0) && !tog_vec[0]);

  p_bus_cancel_r6: assert property (@(posedge clk) disable iff (!srst_n)
    bus_rst |=> (eprst_q == '0));

  p_eprst_selfclr_r3: assert property (@(posedge clk) disable iff (!srst_n)
    ((|eprst_q) && !eprst_we) |=> (eprst_q == '0));

  p_tog_hold_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (!bus_rst && !rstdt_cmd && !xfer_ok) |=> (tog_vec == $past(tog_vec)));

  p_eorst_source_r7: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(eorst_int) |-> ($past(bus_rst_q) && !$past(bus_rst)));

  p_speed_hold_r7: assert property (@(posedge clk) disable iff (!srst_n)
    !(bus_rst_q && !bus_rst) |=> $stable(speed_hs));

  p_epnum_range_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (int'(cpu_ep) < NUM_EP) && (int'(dfc_ep) < NUM_EP));

endmodule

bind ep_state_mgr ep_state_chk #(.NUM_EP(NUM_EP), .EPN_W(EPN_W)) u_chk (
  .clk      (clk),
  .srst_n   (srst_n),
  .bus_rst  (bus_rst),
  .bus_rst_q(bus_rst_q),
  .rstdt_cmd(rstdt_cmd),
  .xfer_ok  (xfer_ok),
  .eprst_we (eprst_we),
  .eprst_q  (eprst_q),
  .en_vec   (en_vec),
  .tog_vec  (tog_vec),
  .cpu_ep   (cpu_ep),
  .dfc_ep   (dfc_ep),
  .eorst_int(eorst_int),
  .speed_hs (speed_hs)
);

// File: tb/ep_state_mgr_bench.sv
`timescale 1ns/1ps
module ep_state_mgr_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en_we;
  logic [6:0] en_wdata, en_vec;
  logic       eprst_we;
  logic [6:0] eprst_wdata, eprst_rdata;
  logic       rstdt_cmd, epnum_sel, epnum_we;
  logic [2:0] epnum_wdata, epnum_rdata;
  logic       dfc_rdy_we, dfc_rdy_wdata, dfc_grant, cpu_acc, dfc_acc;
  logic [5:0] cpu_ptr, dfc_ptr;
  logic       xfer_ok;
  logic [2:0] xfer_ep;
  logic [6:0] tog_vec, ep_int;
  logic       setup_rx, setup_clr;
  logic [2:0] setup_ep;
  logic       bus_rst, hs_det, eorst_clr, eorst_int, speed_hs;

  int vectors = 0;
  int miscompares = 0;

  always #2 clk = ~clk;

  ep_state_mgr u_ep_state_mgr (
    .clk(clk), .rst_n(rst_n), .en_we(en_we), .en_wdata(en_wdata), .en_vec(en_vec),
    .eprst_we(eprst_we), .eprst_wdata(eprst_wdata), .eprst_rdata(eprst_rdata),
    .rstdt_cmd(rstdt_cmd), .epnum_sel(epnum_sel), .epnum_we(epnum_we),
    .epnum_wdata(epnum_wdata), .epnum_rdata(epnum_rdata), .dfc_rdy_we(dfc_rdy_we),
    .dfc_rdy_wdata(dfc_rdy_wdata), .dfc_grant(dfc_grant), .cpu_acc(cpu_acc),
    .dfc_acc(dfc_acc), .cpu_ptr(cpu_ptr), .dfc_ptr(dfc_ptr), .xfer_ok(xfer_ok),
    .xfer_ep(xfer_ep), .tog_vec(tog_vec), .setup_rx(setup_rx), .setup_ep(setup_ep),
    .setup_clr(setup_clr), .ep_int(ep_int), .bus_rst(bus_rst), .hs_det(hs_det),
    .eorst_clr(eorst_clr), .eorst_int(eorst_int), .speed_hs(speed_hs)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    en_we = 0; en_wdata = '0; eprst_we = 0; eprst_wdata = '0; rstdt_cmd = 0;
    epnum_we = 0; epnum_wdata = '0; dfc_rdy_we = 0; dfc_rdy_wdata = 0;
    cpu_acc = 0; dfc_acc = 0; xfer_ok = 0; xfer_ep = '0; setup_rx = 0;
    setup_ep = '0; setup_clr = 0; bus_rst = 0; hs_det = 0; eorst_clr = 0;
  endtask

  task automatic wr_epnum(input logic sel, input logic [2:0] v);
    epnum_sel = sel; epnum_we = 1; epnum_wdata = v;
    tick();
    epnum_we = 0;
  endtask

  task automatic flip(input logic [2:0] ep);
    xfer_ok = 1; xfer_ep = ep;
    tick();
    xfer_ok = 0;
  endtask

  task automatic t_reset();
    chk("R1 en_vec", en_vec, 7'h01);
    chk("R1 tog_vec", tog_vec, 0);
    chk("R1 ep_int", ep_int, 0);
    chk("R1 eprst", eprst_rdata, 0);
    chk("R1 cpu_ptr", cpu_ptr, 0);
    chk("R1 epnum", epnum_rdata, 0);
    chk("R1 grant", dfc_grant, 0);
    chk("R1 eorst", eorst_int, 0);
    chk("R1 speed full", speed_hs, 0);
    en_we = 1; en_wdata = 7'h7F;
    tick();
    en_we = 0;
    chk("R1 enable write", en_vec, 7'h7F);
  endtask

  task automatic t_epnum();
    wr_epnum(0, 3);
    chk("R8 cpu number", epnum_rdata, 3);
    wr_epnum(1, 5);
    chk("R8 dfc number", epnum_rdata, 5);
    epnum_sel = 0; tick();
    chk("R8 cpu kept", epnum_rdata, 3);
    wr_epnum(0, 7);
    chk("R8 out of range ignored", epnum_rdata, 3);
    epnum_sel = 1; tick();
    chk("R8 dfc kept", epnum_rdata, 5);
    epnum_sel = 0;
  endtask

  task automatic t_ptr();
    cpu_acc = 1; repeat (3) tick(); cpu_acc = 0;
    chk("R9 cpu advance", cpu_ptr, 3);
    dfc_acc = 1; tick(); dfc_acc = 0;
    chk("R9 not ready", dfc_ptr, 0);
    chk("R9 grant low", dfc_grant, 0);
    dfc_rdy_we = 1; dfc_rdy_wdata = 1; tick(); dfc_rdy_we = 0;
    chk("R9 grant high", dfc_grant, 1);
    dfc_acc = 1; repeat (2) tick(); dfc_acc = 0;
    chk("R9 dfc advance", dfc_ptr, 2);
    wr_epnum(0, 5);
    cpu_acc = 1; dfc_acc = 1; tick(); cpu_acc = 0; dfc_acc = 0;
    chk("R9 same ep once", dfc_ptr, 3);
    wr_epnum(0, 3);
    chk("R9 other ep kept", cpu_ptr, 3);
  endtask

  task automatic t_wrap();
    wr_epnum(0, 2);
    cpu_acc = 1; repeat (65) tick(); cpu_acc = 0;
    chk("R11 wrap", cpu_ptr, 1);
    wr_epnum(0, 3);
  endtask

  task automatic t_toggle();
    flip(3);
    chk("R4 flip", tog_vec, 7'h08);
    rstdt_cmd = 1; xfer_ok = 1; xfer_ep = 3; tick(); rstdt_cmd = 0; xfer_ok = 0;
    chk("R4 clear wins", tog_vec, 7'h00);
    flip(4); flip(3); flip(6);
    chk("R4 multi flip", tog_vec, 7'h58);
  endtask

  task automatic t_setup();
    setup_rx = 1; setup_ep = 0; tick(); setup_rx = 0;
    chk("R10 setup ep0", ep_int, 7'h01);
    wr_epnum(0, 0);
    setup_rx = 1; setup_clr = 1; tick(); setup_rx = 0; setup_clr = 0;
    chk("R10 set wins", ep_int, 7'h01);
    setup_clr = 1; tick(); setup_clr = 0;
    chk("R10 clear", ep_int, 7'h00);
    setup_rx = 1; setup_ep = 3; tick(); setup_rx = 0;
    chk("R10 setup ep3", ep_int, 7'h08);
    wr_epnum(0, 3);
  endtask

  task automatic t_eprst();
    en_we = 1; en_wdata = 7'h3F; tick(); en_we = 0;
    eprst_we = 1; eprst_wdata = 7'h48; tick(); eprst_we = 0;
    chk("R3 one cycle, disabled masked", eprst_rdata, 7'h08);
    tick();
    chk("R3 self clear", eprst_rdata, 0);
    chk("R2 ptr cleared", cpu_ptr, 0);
    chk("R2 flag cleared", ep_int, 0);
    chk("R2 toggle kept", tog_vec, 7'h58);
    chk("R2 enable kept", en_vec, 7'h3F);
    chk("R2 other ep kept", dfc_ptr, 3);
    flip(6);
    chk("R4 disabled no flip", tog_vec, 7'h58);
    wr_epnum(0, 6);
    cpu_acc = 1; tick(); cpu_acc = 0;
    chk("R9 disabled no advance", cpu_ptr, 0);
  endtask

  task automatic t_busrst();
    wr_epnum(0, 0);
    setup_rx = 1; setup_ep = 0; cpu_acc = 1; xfer_ok = 1; xfer_ep = 0;
    tick();
    idle();
    chk("R5 ep0 prepared", tog_vec, 7'h59);
    chk("R5 ep0 ptr prepared", cpu_ptr, 1);
    bus_rst = 1; hs_det = 1; eprst_we = 1; eprst_wdata = 7'h10;
    setup_rx = 1; setup_ep = 4; xfer_ok = 1; xfer_ep = 3; rstdt_cmd = 1; cpu_acc = 1;
    tick();
    idle(); hs_det = 1;
    chk("R5 disable", en_vec, 7'h01);
    chk("R5 toggles", tog_vec, 7'h58);
    chk("R5 ep0 ptr", cpu_ptr, 0);
    chk("R5 ep0 flag", ep_int, 0);
    chk("R6 eprst ignored", eprst_rdata, 0);
    chk("R9 grant after disable", dfc_grant, 0);
    chk("R7 not yet", eorst_int, 0);
    tick();
    chk("R7 eorst set", eorst_int, 1);
    chk("R7 high speed", speed_hs, 1);
    chk("R6 no late reset", eprst_rdata, 0);
    eorst_clr = 1; tick(); eorst_clr = 0;
    chk("R7 clear", eorst_int, 0);
    bus_rst = 1; hs_det = 0; tick();
    bus_rst = 0; eorst_clr = 1; tick(); eorst_clr = 0;
    chk("R7 set wins", eorst_int, 1);
    chk("R7 full speed", speed_hs, 0);
  endtask

  initial begin
    #400000;
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 0; epnum_sel = 0;
    idle();
    repeat (3) tick();
    rst_n = 1;
    repeat (3) tick();
    t_reset();
    t_epnum();
    t_ptr();
    t_wrap();
    t_toggle();
    t_setup();
    t_eprst();
    t_busrst();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule